// File: doc/BRIEF.md
# YUV 4:2:0 Tile Packer

The packer takes a raster stream of camera pixels, one pixel per transfer with separate luma and chroma samples. It rebuilds the pixels into 48-byte memory chunks. Each chunk covers a strip 16 pixels wide and two rows tall. It holds 32 luma bytes, then 8 U bytes and then 8 V bytes. Each chroma byte is the rounded mean of the four samples of one 2x2 pixel block. Inside every group of the chunk the order is reversed, so the rightmost pixel, or the rightmost pixel pair, comes first. A downstream writer stores the chunks in arrival order.

The first row of each row pair is held in an internal line store. For every pixel pair the store also keeps the sum of the two chroma samples. During the second row the packer gathers 16 pixels at a time. On the 16th pixel the complete chunk is copied into an output register in one cycle. The chunk is then sent as bytes on a valid/ready port, with a marker on the last byte. Back-pressure rules: `out_data` and `out_last` stay stable while `out_valid` is high and `out_ready` is low. `in_ready` falls only when a second-row pixel would complete a chunk while the previous chunk is still being sent. `in_ready` depends on internal state only. `in_sof` marks the first pixel of a frame and restarts the position count. Chunks left incomplete at that point are dropped. The line width is a parameter and must be a multiple of 16, at least 32.

Top module: `yuv_tile_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Every chunk is exactly 48 output transfers. `out_last` is 1 on the 48th transfer of a chunk and 0 on all the others. `out_valid` falls only after the last byte has been accepted.
- R3: Bytes 0..15 of a chunk are the first-row luma of the strip in reverse column order. Byte 0 is strip column 15 and byte 15 is strip column 0.
- R4: Bytes 16..31 are the second-row luma of the same 16 columns, also reversed. Byte 16 is column 15.
- R5: Bytes 32..39 are the 8 U values and bytes 40..47 are the 8 V values. Each group is in reverse pair order: byte 32 (or 40) belongs to columns 14/15 and byte 39 (or 47) to columns 0/1.
- R6: Each chroma byte equals (a+b+c+d+2)>>2, where a..d are the four samples of its 2x2 block.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold. No input pixel is lost under any stall pattern.
- R8: `in_ready` is 0 only while a chunk is being sent (`out_valid` is 1).
- R9: A pixel with `in_sof`=1 is taken as column 0 of the first row of a new frame. Chunks not completed before it are never emitted.
- R10: Chunks leave in order: strips left to right within a row pair, then row pairs top to bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Packer accepts the pixel this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | U sample |
| in_v | input | 8 | V sample |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of a 48-byte chunk |

## Verification
The assertions rely on a defined `out_ready` in every cycle after reset. They also rely on the frame order coming only from `in_sof`, so `in_valid` may fall between any two pixels. The bench drives `in_valid` with random idle gaps and `out_ready` with random or forced stalls. It does not assume that `in_ready` stays high. The bench starts every frame with `in_sof`, keeps the line width at the default, and uses frames of whole row pairs. The one exception is a frame that is deliberately cut short to exercise R9.

// File: rtl/ytp_pkg.sv
package ytp_pkg;
  localparam int STRIP_W     = 16;
  localparam int STRIP_PAIRS = STRIP_W / 2;
  localparam int CHUNK_BYTES = 2 * STRIP_W + 2 * STRIP_PAIRS;
  localparam int CHUNK_BITS  = CHUNK_BYTES * 8;

  typedef logic [7:0] sample_t;
  typedef logic [8:0] pair_sum_t;

  // rounded mean of four samples given as two pair sums
  function automatic sample_t quad_mean(pair_sum_t upper, pair_sum_t lower);
    logic [9:0] total;
    total = {1'b0, upper} + {1'b0, lower} + 10'd2;
    return sample_t'(total >> 2);
  endfunction
endpackage

// File: rtl/ytp_line_store.sv
module ytp_line_store
  import ytp_pkg::*;
#(
  parameter int LINE_W = 64
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [$clog2(LINE_W)-1:0]    wr_col,
  input  sample_t                      wr_y,
  input  sample_t                      wr_u,
  input  sample_t                      wr_v,
  input  logic [$clog2(LINE_W)-1:0]    rd_col,
  output pair_sum_t                    rd_sum_u,
  output pair_sum_t                    rd_sum_v,
  output logic [STRIP_W*8-1:0]         strip_y
);
  localparam int CW    = $clog2(LINE_W);
  localparam int NPAIR = LINE_W / 2;

  sample_t   luma_mem [LINE_W];
  pair_sum_t usum_mem [NPAIR];
  pair_sum_t vsum_mem [NPAIR];

  logic [CW-2:0] wr_pair;
  assign wr_pair = wr_col[CW-1:1];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      luma_mem[wr_col] <= wr_y;
      if (!wr_col[0]) begin
        usum_mem[wr_pair] <= {1'b0, wr_u};
        vsum_mem[wr_pair] <= {1'b0, wr_v};
      end else begin
        usum_mem[wr_pair] <= usum_mem[wr_pair] + {1'b0, wr_u};
        vsum_mem[wr_pair] <= vsum_mem[wr_pair] + {1'b0, wr_v};
      end
    end
  end

  assign rd_sum_u = usum_mem[rd_col[CW-1:1]];
  assign rd_sum_v = vsum_mem[rd_col[CW-1:1]];

  for (genvar i = 0; i < STRIP_W; i++) begin : g_strip
    assign strip_y[i*8 +: 8] = luma_mem[{rd_col[CW-1:4], 4'(i)}];
  end
endmodule

// File: rtl/ytp_strip_collect.sv
module ytp_strip_collect
  import ytp_pkg::*;
(
  input  logic                      clk,
  input  logic                      take,
  input  logic [3:0]                col_lo,
  input  sample_t                   in_y,
  input  sample_t                   in_u,
  input  sample_t                   in_v,
  input  pair_sum_t                 line_su,
  input  pair_sum_t                 line_sv,
  output logic [STRIP_W*8-1:0]      low_y,
  output logic [STRIP_PAIRS*8-1:0]  mean_u,
  output logic [STRIP_PAIRS*8-1:0]  mean_v
);
  sample_t luma_q [STRIP_W-1];
  sample_t cu_q   [STRIP_PAIRS-1];
  sample_t cv_q   [STRIP_PAIRS-1];
  sample_t part_u, part_v;

  sample_t   cur_mu, cur_mv;
  pair_sum_t low_su, low_sv;

  assign low_su = {1'b0, part_u} + {1'b0, in_u};
  assign low_sv = {1'b0, part_v} + {1'b0, in_v};
  assign cur_mu = quad_mean(line_su, low_su);
  assign cur_mv = quad_mean(line_sv, low_sv);

  always_ff @(posedge clk) begin
    if (take) begin
      for (int i = 0; i < STRIP_W - 1; i++)
        if (col_lo == 4'(i)) luma_q[i] <= in_y;
      if (!col_lo[0]) begin
        part_u <= in_u;
        part_v <= in_v;
      end else begin
        for (int p = 0; p < STRIP_PAIRS - 1; p++)
          if (col_lo[3:1] == 3'(p)) begin
            cu_q[p] <= cur_mu;
            cv_q[p] <= cur_mv;
          end
      end
    end
  end

  // the final pixel of the strip is merged straight from the input
  for (genvar i = 0; i < STRIP_W - 1; i++) begin : g_ly
    assign low_y[i*8 +: 8] = luma_q[i];
  end
  assign low_y[(STRIP_W-1)*8 +: 8] = in_y;

  for (genvar p = 0; p < STRIP_PAIRS - 1; p++) begin : g_c
    assign mean_u[p*8 +: 8] = cu_q[p];
    assign mean_v[p*8 +: 8] = cv_q[p];
  end
  assign mean_u[(STRIP_PAIRS-1)*8 +: 8] = cur_mu;
  assign mean_v[(STRIP_PAIRS-1)*8 +: 8] = cur_mv;
endmodule

// File: rtl/ytp_chunk_emit.sv
module ytp_chunk_emit
  import ytp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [STRIP_W*8-1:0]      top_y,
  input  logic [STRIP_W*8-1:0]      low_y,
  input  logic [STRIP_PAIRS*8-1:0]  mean_u,
  input  logic [STRIP_PAIRS*8-1:0]  mean_v,
  output logic                      out_valid,
  input  logic                      out_ready,
  output sample_t                   out_data,
  output logic                      out_last
);
  localparam int IW = $clog2(CHUNK_BYTES);
  localparam int U0 = 2 * STRIP_W;
  localparam int V0 = U0 + STRIP_PAIRS;

  logic [CHUNK_BITS-1:0] ordered, stage_q;
  logic [IW-1:0]         idx_q;
  logic                  valid_q;

  for (genvar k = 0; k < CHUNK_BYTES; k++) begin : g_ord
    if (k < STRIP_W) begin : g_top
      assign ordered[k*8 +: 8] = top_y[(STRIP_W-1-k)*8 +: 8];
    end else if (k < U0) begin : g_low
      assign ordered[k*8 +: 8] = low_y[(U0-1-k)*8 +: 8];
    end else if (k < V0) begin : g_u
      assign ordered[k*8 +: 8] = mean_u[(V0-1-k)*8 +: 8];
    end else begin : g_v
      assign ordered[k*8 +: 8] = mean_v[(CHUNK_BYTES-1-k)*8 +: 8];
    end
  end

  logic advance, at_end;
  assign advance = valid_q && out_ready;
  assign at_end  = idx_q == IW'(CHUNK_BYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      idx_q   <= '0;
    end else if (advance) begin
      if (at_end) valid_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load) stage_q <= ordered;
    else if (advance) stage_q <= {8'h00, stage_q[CHUNK_BITS-1:8]};
  end

  assign out_valid = valid_q;
  assign out_data  = stage_q[7:0];
  assign out_last  = valid_q && at_end;
endmodule

// File: rtl/yuv_tile_packer.sv
module yuv_tile_packer
  import ytp_pkg::*;
#(
  parameter int LINE_W = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  logic    in_sof,
  input  sample_t in_y,
  input  sample_t in_u,
  input  sample_t in_v,
  output logic    out_valid,
  input  logic    out_ready,
  output sample_t out_data,
  output logic    out_last
);
  localparam int CW = $clog2(LINE_W);

  logic [CW-1:0] col_q, eff_col;
  logic          odd_q, eff_odd;
  logic          accept, strip_end;

  assign eff_col   = in_sof ? '0 : col_q;
  assign eff_odd   = in_sof ? 1'b0 : odd_q;
  assign in_ready  = !(odd_q && (col_q[3:0] == 4'hF) && out_valid);
  assign accept    = in_valid && in_ready;
  assign strip_end = eff_col[3:0] == 4'hF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      odd_q <= 1'b0;
    end else if (accept) begin
      if (eff_col == CW'(LINE_W - 1)) begin
        col_q <= '0;
        odd_q <= !eff_odd;
      end else begin
        col_q <= eff_col + 1'b1;
        odd_q <= eff_odd;
      end
    end
  end

  pair_sum_t                 su, sv;
  logic [STRIP_W*8-1:0]      top_y, low_y;
  logic [STRIP_PAIRS*8-1:0]  mu, mv;

  ytp_line_store #(.LINE_W(LINE_W)) u_line (
    .clk      (clk),
    .wr_en    (accept && !eff_odd),
    .wr_col   (eff_col),
    .wr_y     (in_y),
    .wr_u     (in_u),
    .wr_v     (in_v),
    .rd_col   (eff_col),
    .rd_sum_u (su),
    .rd_sum_v (sv),
    .strip_y  (top_y)
  );

  ytp_strip_collect u_collect (
    .clk     (clk),
    .take    (accept && eff_odd),
    .col_lo  (eff_col[3:0]),
    .in_y    (in_y),
    .in_u    (in_u),
    .in_v    (in_v),
    .line_su (su),
    .line_sv (sv),
    .low_y   (low_y),
    .mean_u  (mu),
    .mean_v  (mv)
  );

  ytp_chunk_emit u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && eff_odd && strip_end),
    .top_y     (top_y),
    .low_y     (low_y),
    .mean_u    (mu),
    .mean_v    (mv),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );
endmodule

// File: rtl/ytp_checker.sv
module ytp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);
  logic [5:0] sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sent_q <= '0;
    else if (out_valid && out_ready) sent_q <= (sent_q == 6'd47) ? 6'd0 : sent_q + 6'd1;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_last_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (sent_q == 6'd47)));

  assert_chunk_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_valid && out_ready && out_last));

  assert_stall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);
endmodule

bind yuv_tile_packer ytp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/tb_yuv_tile_packer.sv
module tb_yuv_tile_packer;
  localparam int LW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
  logic [7:0] in_y = '0, in_u = '0, in_v = '0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  yuv_tile_packer #(.LINE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  int n_vec = 0, n_bad = 0;
  logic [7:0] exp_q [0:8191];
  int wr_p = 0, rd_p = 0;
  int stall_pct = 0;
  bit gaps = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int hsh(int a);
    int unsigned x;
    x = a;
    x = x * 32'h9E3779B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA6B;
    return int'(x >> 24);
  endfunction

  // ch: 0=Y 1=U 2=V
  function automatic int pix(int mode, int seed, int r, int c, int ch);
    case (mode)
      0: case (ch)
           0: return (r * 16 + c) & 255;
           1: return (r * 5 + c * 3 + 40) & 255;
           default: return (200 - r * 3 - c) & 255;
         endcase
      1: return hsh(r * 1000 + c * 7 + ch * 100003 + seed * 7919);
      default: case (ch)
           0: return c & 255;
           1: return (r % 2 == 0 && c % 2 == 0) ? ((c >> 1) % 4) : 0;
           default: return (r % 2 == 1 && c % 2 == 1) ? 252 + ((c >> 1) % 4) : 255;
         endcase
    endcase
  endfunction

  function automatic int cmean(int mode, int seed, int r, int c, int ch);
    int s;
    s = pix(mode, seed, r, c, ch) + pix(mode, seed, r, c + 1, ch)
      + pix(mode, seed, r + 1, c, ch) + pix(mode, seed, r + 1, c + 1, ch);
    return (s + 2) >> 2;
  endfunction

  task automatic add_chunk(input int mode, input int seed, input int rp, input int s);
    int b, r;
    b = s * 16;
    r = rp * 2;
    for (int k = 0; k < 48; k++) begin
      if (k < 16)      exp_q[wr_p] = 8'(pix(mode, seed, r, b + 15 - k, 0));
      else if (k < 32) exp_q[wr_p] = 8'(pix(mode, seed, r + 1, b + 31 - k, 0));
      else if (k < 40) exp_q[wr_p] = 8'(cmean(mode, seed, r, b + 2 * (39 - k), 1));
      else             exp_q[wr_p] = 8'(cmean(mode, seed, r, b + 2 * (47 - k), 2));
      wr_p++;
    end
  endtask

  // caller is at a falling edge
  task automatic put_pixel(input int y, input int u, input int v, input bit sof);
    bit ok;
    if (gaps && ($urandom % 4 == 0)) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_sof = sof;
    in_y = 8'(y); in_u = 8'(u); in_v = 8'(v);
    do begin
      #4 ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
    in_sof = 1'b0;
  endtask

  task automatic send_frame(input int mode, input int seed, input int nrows, input int tail);
    int limit;
    for (int r = 0; r < nrows; r++) begin
      limit = (r == nrows - 1 && tail > 0) ? tail : LW;
      for (int c = 0; c < limit; c++)
        put_pixel(pix(mode, seed, r, c, 0), pix(mode, seed, r, c, 1),
                  pix(mode, seed, r, c, 2), r == 0 && c == 0);
    end
  endtask

  task automatic expect_frame(input int mode, input int seed, input int npairs);
    for (int rp = 0; rp < npairs; rp++)
      for (int s = 0; s < LW / 16; s++) add_chunk(mode, seed, rp, s);
  endtask

  task automatic drain(input string req);
    int t;
    t = 0;
    while ((rd_p != wr_p || out_valid) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (20) @(negedge clk);
    check(rd_p == wr_p, req, rd_p, wr_p);
    check(out_valid == 1'b0, req, int'(out_valid), 0);
  endtask

  // output side: ready driver and monitor
  initial begin
    forever begin
      @(negedge clk);
      out_ready = (stall_pct == 0) ? 1'b1 : (($urandom % 100) >= stall_pct);
    end
  end

  bit prev_hold = 0;
  logic [7:0] prev_data;
  logic prev_last;
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rst_n) begin
        if (prev_hold) begin
          check(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
          check(out_data == prev_data, "R7 data held", out_data, prev_data);
          check(out_last == prev_last, "R7 last held", int'(out_last), int'(prev_last));
        end
        if (!in_ready) check(out_valid == 1'b1, "R8 stall only while sending", int'(out_valid), 1);
        if (out_valid && out_ready) begin
          if (rd_p >= wr_p) check(1'b0, "R9 unexpected byte", rd_p, wr_p);
          else begin
            if (rd_p % 48 < 16)      check(out_data == exp_q[rd_p], "R3 top luma", out_data, exp_q[rd_p]);
            else if (rd_p % 48 < 32) check(out_data == exp_q[rd_p], "R4 low luma", out_data, exp_q[rd_p]);
            else                     check(out_data == exp_q[rd_p], "R5 R6 chroma", out_data, exp_q[rd_p]);
            check(out_last == (rd_p % 48 == 47), "R2 last marker", int'(out_last), int'(rd_p % 48 == 47));
          end
          rd_p++;
        end
        prev_hold = out_valid && !out_ready;
        prev_data = out_data;
        prev_last = out_last;
      end
    end
  end

  task automatic t_reset();
    #4;
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    @(negedge clk);
  endtask

  task automatic t_ramp();
    stall_pct = 0; gaps = 0;
    expect_frame(0, 0, 1);
    send_frame(0, 0, 2, 0);
    drain("R10 ramp frame");
  endtask

  task automatic t_random_stall();
    stall_pct = 40; gaps = 1;
    expect_frame(1, 3, 2);
    send_frame(1, 3, 4, 0);
    drain("R7 random stalls");
    stall_pct = 0; gaps = 0;
  endtask

  task automatic t_round();
    expect_frame(2, 0, 1);
    send_frame(2, 0, 2, 0);
    drain("R6 rounding");
  endtask

  task automatic t_partial();
    add_chunk(1, 5, 0, 0);
    send_frame(1, 5, 2, 20);
    expect_frame(0, 0, 1);
    send_frame(0, 0, 2, 0);
    drain("R9 partial frame");
  endtask

  task automatic t_backpressure();
    int t;
    bit seen;
    stall_pct = 100;
    expect_frame(1, 9, 1);
    fork
      send_frame(1, 9, 2, 0);
      begin
        seen = 0; t = 0;
        while (!seen && t < 1000) begin
          #4 seen = !in_ready;
          @(negedge clk);
          t++;
        end
        check(seen, "R8 input stalled", int'(seen), 1);
        repeat (30) @(negedge clk);
        #4 check(in_ready == 1'b0, "R8 stall persists", int'(in_ready), 0);
        @(negedge clk);
        stall_pct = 0;
      end
    join
    drain("R7 backpressure no loss");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ramp();
    t_random_stall();
    t_round();
    t_partial();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R10 act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule